// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a small processor core that completes each instruction in one clock cycle. Each cycle it fetches a 32-bit word from its instruction store at the program counter and decodes it. It reads two source registers, computes a result or an address, and commits the result at the closing clock edge. It handles six operations: unsigned add, unsigned subtract, OR with a zero-extended immediate, word load, word store and branch-if-equal. It contains a 32-entry, 32-bit register file whose entry 0 always reads zero, and a 256-word data store addressed by byte address.

Software-free bring-up uses a load port into the instruction store. While reset is held, a program is written one word per cycle. Releasing reset starts execution at address 0. The program counter is always visible. Register and data-store contents can be observed through two probe ports that return the addressed word one cycle after the address is presented.

Top module: `scd_core`

## Requirements
- R1: While `rst` is high, `pc_o` is 0 from the cycle after the first reset edge, and no register or data-store write happens.
- R2: An R-format word (opcode bits [31:26] = 0x00, shamt bits [10:6] = 0) with funct bits [5:0] = 0x21 writes rs+rt (modulo 2^32) into rd. With funct 0x23 it writes rs−rt (modulo 2^32) into rd. rs is bits [25:21], rt is bits [20:16] and rd is bits [15:11].
- R3: Opcode 0x0D writes rs OR the zero-extended 16-bit immediate (bits [15:0]) into rt.
- R4: Opcode 0x23 loads the data word at byte address rs + sign-extended immediate into rt. The word index is address bits [9:2].
- R5: Opcode 0x2B stores rt to the data word at byte address rs + sign-extended immediate, with the word index taken from bits [9:2]. It writes no register.
- R6: Opcode 0x04 sets the next PC to PC+4+4×sign-extended immediate when rs equals rt, and to PC+4 otherwise. A negative offset branches backward.
- R7: Writes aimed at register 0 are discarded, and register 0 reads as zero.
- R8: Any other opcode, and any R-format word with an unknown funct or a non-zero shamt, changes no register or data word, and the PC advances by 4.
- R9: A result written in one cycle is the operand seen by the instruction in the next cycle.
- R10: `rprobe_data` and `mprobe_data` show the register or data word selected by the probe address, sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction-store write strobe |
| imem_waddr | input | 6 | Instruction-store word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter |
| rprobe_addr | input | 5 | Register number to observe |
| rprobe_data | output | 32 | Registered contents of the probed register |
| mprobe_addr | input | 8 | Data-store word index to observe |
| mprobe_data | output | 32 | Registered contents of the probed data word |

## Verification
One fixed 21-instruction program is run with six operand pairs taken from the immediate field. The pairs include zero, all-ones, the sign-bit pattern and cases where the first operand is smaller. Together they separate correct wrap-around subtraction and addition carries from truncated results, and zero extension from sign extension. Equal and unequal pairs steer the same branch both ways. A backward self-branch ends each run, so the final PC shows whether the backward target arithmetic is right. A negative store/load offset from a non-zero base checks sign extension of addresses. Writes aimed at register 0 and two undecodable words are placed between known values, so that any stray write shows up at the register probe.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;
  localparam int NREG = 1 << RAW;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    dst_rd;     // write address from rd instead of rt
    logic    use_imm;    // second ALU operand is the extended immediate
    logic    sext;       // sign-extend the immediate
    logic    st_en;      // data-store write
    logic    wb_mem;     // write back the loaded word
    logic    wr_en;      // register write
    logic    is_branch;  // conditional branch on equality
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/scd_decode.sv
module scd_decode
  import scd_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '{dst_rd: 1'b0, use_imm: 1'b0, sext: 1'b0, st_en: 1'b0,
            wb_mem: 1'b0, wr_en: 1'b0, is_branch: 1'b0, alu_op: ALU_ADD};
    case (op)
      OP_RTYPE: begin
        if (shamt == '0) begin
          case (funct)
            FN_ADDU: begin ctl.dst_rd = 1'b1; ctl.wr_en = 1'b1; ctl.alu_op = ALU_ADD; end
            FN_SUBU: begin ctl.dst_rd = 1'b1; ctl.wr_en = 1'b1; ctl.alu_op = ALU_SUB; end
            default: ;
          endcase
        end
      end
      OP_ORI: begin ctl.use_imm = 1'b1; ctl.wr_en = 1'b1; ctl.alu_op = ALU_OR; end
      OP_LW:  begin ctl.use_imm = 1'b1; ctl.sext = 1'b1; ctl.wb_mem = 1'b1; ctl.wr_en = 1'b1; end
      OP_SW:  begin ctl.use_imm = 1'b1; ctl.sext = 1'b1; ctl.st_en = 1'b1; end
      OP_BEQ: begin ctl.sext = 1'b1; ctl.is_branch = 1'b1; end
      default: ;
    endcase
  end

  // R5: a store never also writes a register
  always_comb assert_store_no_regwr_R5: assert (!(ctl.st_en && ctl.wr_en));
endmodule

// File: rtl/scd_regfile.sv
module scd_regfile #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rda,
  input  logic [AW-1:0] rb,
  output logic [DW-1:0] rdb,
  input  logic [AW-1:0] pa,
  output logic [DW-1:0] pd
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] regs [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rda = (ra == '0) ? '0 : regs[ra];
  assign rdb = (rb == '0) ? '0 : regs[rb];
  assign pd  = (pa == '0) ? '0 : regs[pa];

  // R9: a write is visible on the read port in the following cycle
  assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));
  // R7: register 0 reads as zero
  assert_zero_reg_R7: assert property (@(posedge clk) disable iff (rst)
    (ra == '0) |-> (rda == '0));
endmodule

// File: rtl/scd_alu.sv
module scd_alu
  import scd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y,
  output logic          eq
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
  assign eq = (a == b);
endmodule

// File: rtl/scd_dmem.sv
module scd_dmem #(
  parameter int DW = 32,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd,
  input  logic [IW-1:0] pidx,
  output logic [DW-1:0] pd
);
  localparam int DEPTH = 1 << IW;
  logic [DW-1:0] words [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) words[idx] <= wd;
  end
  assign rd = words[idx];
  assign pd = words[pidx];

  // R5: a store lands at its word index
  assert_store_lands_R5: assert property (@(posedge clk) disable iff (rst)
    we |=> (words[$past(idx)] == $past(wd)));
endmodule

// File: rtl/scd_core.sv
module scd_core
  import scd_pkg::*;
#(
  parameter int IM_AW = 6,
  parameter int DM_AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             imem_we,
  input  logic [IM_AW-1:0] imem_waddr,
  input  logic [31:0]      imem_wdata,
  output logic [31:0]      pc_o,
  input  logic [RAW-1:0]   rprobe_addr,
  output logic [31:0]      rprobe_data,
  input  logic [DM_AW-1:0] mprobe_addr,
  output logic [31:0]      mprobe_data
);
  localparam int IM_DEPTH = 1 << IM_AW;

  logic [XLEN-1:0] pc, pc_plus4, br_tgt, pc_next;
  logic [31:0]     imem [0:IM_DEPTH-1];
  logic [31:0]     instr;
  ctrl_t           ctl;
  logic [RAW-1:0]  rs, rt, rd, waddr;
  logic [15:0]     imm;
  logic [XLEN-1:0] imm_sx, imm_zx, imm_ext, br_off;
  logic [XLEN-1:0] opa, opb, alu_b, alu_y, ld_data, wb_data;
  logic [XLEN-1:0] rf_pd, dm_pd;
  logic            eq, taken;

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_waddr] <= imem_wdata;
  end
  assign instr = imem[pc[IM_AW+1:2]];

  assign rs  = instr[25:21];
  assign rt  = instr[20:16];
  assign rd  = instr[15:11];
  assign imm = instr[15:0];

  scd_decode u_dec (
    .op(instr[31:26]), .funct(instr[5:0]), .shamt(instr[10:6]), .ctl(ctl)
  );

  assign imm_sx  = {{(XLEN-16){imm[15]}}, imm};
  assign imm_zx  = {{(XLEN-16){1'b0}}, imm};
  assign imm_ext = ctl.sext ? imm_sx : imm_zx;
  assign waddr   = ctl.dst_rd ? rd : rt;

  scd_regfile #(.DW(XLEN), .AW(RAW)) u_rf (
    .clk(clk), .rst(rst), .we(ctl.wr_en & ~rst), .wa(waddr), .wd(wb_data),
    .ra(rs), .rda(opa), .rb(rt), .rdb(opb), .pa(rprobe_addr), .pd(rf_pd)
  );

  assign alu_b = ctl.use_imm ? imm_ext : opb;

  scd_alu #(.DW(XLEN)) u_alu (
    .a(opa), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .eq(eq)
  );

  scd_dmem #(.DW(XLEN), .IW(DM_AW)) u_dm (
    .clk(clk), .rst(rst), .we(ctl.st_en & ~rst), .idx(alu_y[DM_AW+1:2]),
    .wd(opb), .rd(ld_data), .pidx(mprobe_addr), .pd(dm_pd)
  );

  assign wb_data = ctl.wb_mem ? ld_data : alu_y;

  assign pc_plus4 = pc + 32'd4;
  assign br_off   = imm_sx << 2;
  assign br_tgt   = pc_plus4 + br_off;
  assign taken    = ctl.is_branch & eq;
  assign pc_next  = taken ? br_tgt : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
    rprobe_data <= rf_pd;
    mprobe_data <= dm_pd;
  end
  assign pc_o = pc;

  // R1: reset forces the PC to zero
  assert_pc_reset_R1: assert property (@(posedge clk) rst |=> (pc_o == '0));
  // R8: any non-taken instruction steps the PC by one word
  assert_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
    !taken |=> (pc_o == $past(pc_o) + 32'd4));
  // R6: a taken branch lands on the word-scaled target
  assert_branch_target_R6: assert property (@(posedge clk) disable iff (rst)
    taken |=> (pc_o == $past(pc_o) + 32'd4 + ($past(imm_sx) << 2)));
endmodule

// File: tb/scd_core_tb.sv
module scd_core_tb_top;
  import scd_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic [31:0] pc_o;
  logic [4:0]  rprobe_addr = '0;
  logic [31:0] rprobe_data;
  logic [7:0]  mprobe_addr = '0;
  logic [31:0] mprobe_data;

  int total = 0;
  int bad   = 0;
  logic [31:0] prog [0:63];

  always #4 clk = ~clk;

  scd_core dut_i (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .pc_o(pc_o), .rprobe_addr(rprobe_addr),
    .rprobe_data(rprobe_data), .mprobe_addr(mprobe_addr), .mprobe_data(mprobe_data)
  );

  function automatic logic [31:0] rtype(input logic [4:0] s, t, d, input logic [5:0] fn);
    return {OP_RTYPE, s, t, d, 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] s, t,
                                        input logic [15:0] im);
    return {op, s, t, im};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
    rprobe_addr = a;
    @(negedge clk);
    v = rprobe_data;
  endtask

  task automatic rd_mem(input logic [7:0] a, output logic [31:0] v);
    mprobe_addr = a;
    @(negedge clk);
    v = mprobe_data;
  endtask

  task automatic build(input logic [15:0] a, input logic [15:0] b);
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    prog[0]  = itype(OP_ORI, 0, 1, a);
    prog[1]  = itype(OP_ORI, 0, 2, b);
    prog[2]  = rtype(1, 2, 3, FN_ADDU);
    prog[3]  = rtype(1, 2, 4, FN_SUBU);
    prog[4]  = rtype(0, 1, 5, FN_SUBU);
    prog[5]  = itype(OP_ORI, 0, 6, 16'h0040);
    prog[6]  = itype(OP_SW, 6, 3, 16'hFFF8);
    prog[7]  = itype(OP_LW, 6, 7, 16'hFFF8);
    prog[8]  = itype(OP_SW, 0, 4, 16'h007C);
    prog[9]  = itype(OP_LW, 0, 8, 16'h007C);
    prog[10] = itype(OP_ORI, 0, 0, 16'h1234);
    prog[11] = rtype(1, 2, 0, FN_ADDU);
    prog[12] = itype(OP_ORI, 0, 9, 16'h0055);
    prog[13] = itype(6'h3F, 1, 9, 16'hFFFF);
    prog[14] = rtype(1, 2, 9, FN_ADDU) | 32'h0000_0040;
    prog[15] = itype(OP_ORI, 0, 10, 16'h0000);
    prog[16] = itype(OP_BEQ, 1, 2, 16'h0001);
    prog[17] = itype(OP_ORI, 0, 10, 16'h0077);
    prog[18] = itype(OP_ORI, 0, 11, 16'h0099);
    prog[19] = rtype(0, 1, 12, FN_ADDU);
    prog[20] = itype(OP_BEQ, 0, 0, 16'hFFFF);
  endtask

  task automatic run_pair(input logic [15:0] a, input logic [15:0] b, input bit first);
    logic [31:0] v, ea, eb, esum, edif;
    build(a, b);
    ea = {16'h0, a};
    eb = {16'h0, b};
    esum = ea + eb;
    edif = ea - eb;
    rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_waddr = i[5:0]; imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    if (first) chk("R1 pc held at zero in reset", pc_o, 32'h0);
    if (first) begin
      rd_mem(8'd14, v);
      chk("R1 no store while in reset", v, 32'hxxxx_xxxx);
    end
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk("R6 backward self-branch halts pc", pc_o, 32'd80);
    rd_reg(1, v);  chk("R3 ori zero-extends into rt (r1)", v, ea);
    rd_reg(2, v);  chk("R3 ori zero-extends into rt (r2)", v, eb);
    rd_reg(3, v);  chk("R2 addu sum", v, esum);
    rd_reg(4, v);  chk("R2 subu difference", v, edif);
    rd_reg(5, v);  chk("R9 subu from zero with fresh operand", v, 32'h0 - ea);
    rd_mem(8'd14, v); chk("R5 store at negative offset word 14", v, esum);
    rd_reg(7, v);  chk("R4 load at negative offset", v, esum);
    rd_mem(8'd31, v); chk("R5 store at word 31", v, edif);
    rd_reg(8, v);  chk("R4 load from word 31", v, edif);
    rd_reg(0, v);  chk("R7 register 0 reads zero", v, 32'h0);
    rd_reg(12, v); chk("R7 register 0 as operand", v, ea);
    rd_reg(9, v);  chk("R8 undecodable words leave r9", v, 32'h55);
    rd_reg(10, v); chk("R6 branch skip depends on equality", v, (a == b) ? 32'h0 : 32'h77);
    rd_reg(11, v); chk("R10 probe shows fall-through write", v, 32'h99);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 pc zero after reset edge", pc_o, 32'h0);
    run_pair(16'h0000, 16'h0000, 1'b1);
    run_pair(16'h0001, 16'h0002, 1'b0);
    run_pair(16'hFFFF, 16'h0001, 1'b0);
    run_pair(16'h8000, 16'h8000, 1'b0);
    run_pair(16'h1234, 16'hFFFF, 1'b0);
    run_pair(16'h0005, 16'h0003, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule